// File: doc/BRIEF.md
# Receive Packet FIFO with Status Queue

This block sits between a receive MAC and a host port. The MAC streams frame bytes into a byte-wide FIFO. At the end of each frame it supplies a 4-bit error code. For every completed frame the block queues a status entry holding the error code and the number of bytes stored. The host sees a 16-bit status word describing the head packet and pulls the packet's data out as 16-bit words, earliest byte in the low half. A discard command drops the head packet and frees whatever is left of it, and the next queued packet then becomes the head.

Reception stalls under two separate conditions. The first is a full data store, flagged with hysteresis until some space has been freed. The second is a status queue that already holds its maximum number of packets. A frame that begins under either condition is dropped whole and leaves no trace. A frame that runs out of space part-way is closed with the overrun code. A host read with nothing left to read is treated as a failure: it raises underrun and adapter failure, and both stay up until a receive-reset command.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After `rst`, or after a command with `cmd_opcode` = 5 (receive reset), the status word is 16'h8000, `host_rd_data` is 0, and `rx_complete`, `rx_receiving`, `rx_fifo_ovr`, `rx_stat_ovr`, `rx_underrun` and `adapter_fail` are all 0. Every stored byte and packet is gone.
- R2: Frames are kept in arrival order. A `host_rd` strobe returns a word with the next unread byte of the head packet in bits 7:0 and the byte after it in bits 15:8. If only one byte remains, bits 15:8 read 0. The word appears on `host_rd_data` in the cycle after the strobe and holds until the next strobe.
- R3: When a completed packet is at the head, status bit 15 is 0, bits 14:11 carry its error code and bits 10:0 its stored byte count (saturating at 2047). Otherwise bit 15 is 1, bits 14:11 are 0, and bits 10:0 count the bytes stored so far for the frame in progress (0 when idle).
- R4: `rx_receiving` is high from the cycle after a frame's first accepted byte to the cycle after its end-of-frame strobe. A byte that comes with the end strobe belongs to that frame.
- R5: `rx_complete` is high while at least one completed packet is held.
- R6: A command with `cmd_opcode` = 8 removes the head packet, frees its unread bytes and exposes the next packet. With no completed packet it does nothing. A read in the same cycle is ignored.
- R7: `rx_stat_ovr` is high while MAX_PKTS packets are held. A frame starting then is dropped entirely. The flag clears once a packet is discarded.
- R8: `rx_fifo_ovr` rises the cycle after occupancy reaches DEPTH and falls the cycle after free space is at least RESUME_FREE bytes. Reads free space. A frame starting while the flag is high is dropped entirely.
- R9: A frame that loses bytes because the store is full completes with the bytes actually kept and error code 4'b1000, whatever the MAC reported.
- R10: A read with no completed packet, or with no unread bytes left in the head packet, returns 0 and sets `rx_underrun` and `adapter_fail`. Both stay set until a receive reset.
- R11: An end-of-frame strobe with no frame in progress, and any opcode other than 5 or 8, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_byte_vld | input | 1 | A received byte is present |
| mac_byte | input | 8 | Received byte |
| mac_frame_end | input | 1 | End of the current frame |
| mac_err_code | input | 4 | Error code of the ending frame |
| host_rd | input | 1 | Read one data word |
| host_rd_data | output | 16 | Last word read |
| host_status | output | 16 | Head packet status word |
| cmd_wr | input | 1 | Command strobe |
| cmd_opcode | input | 5 | Command opcode (5 reset, 8 discard) |
| rx_complete | output | 1 | A completed packet is held |
| rx_receiving | output | 1 | A frame is being stored |
| rx_fifo_ovr | output | 1 | Data store overrun stall |
| rx_stat_ovr | output | 1 | Status queue full stall |
| rx_underrun | output | 1 | Read past available data |
| adapter_fail | output | 1 | Failure indication |

## Verification
On every cycle, the embedded assertions check four things: the packet count stays within MAX_PKTS and never underflows, occupancy never passes DEPTH, underrun stays set once raised until a receive reset, and a frame that starts during either stall never enters the receiving state. The things that take a sequence of operations are left to the bench's scenarios. These include byte order across word reads and the odd trailing byte, the overrun code stamped on a truncated frame, the hysteresis timing of the full stall as reads free space, and the fact that dropped frames leave no status entry. A cycle-by-cycle reference model compares every output throughout.

// File: rtl/rx_pkt_fifo_pkg.sv
package rx_pkt_fifo_pkg;

  localparam logic [4:0] OPC_RX_RESET = 5'd5;
  localparam logic [4:0] OPC_DISCARD  = 5'd8;

  localparam logic [3:0] ERR_OVERRUN  = 4'b1000;

  localparam int unsigned STAT_LEN_W   = 11;
  localparam int unsigned STAT_LEN_MAX = 2047;

  typedef struct packed {
    logic                  incomplete;
    logic [3:0]            code;
    logic [STAT_LEN_W-1:0] len;
  } rx_stat_t;

endpackage

// File: rtl/rx_byte_bank.sv
module rx_byte_bank #(
  parameter int unsigned WORDS = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] wa,
  input  logic [7:0]               wd,
  input  logic                     re,
  input  logic [$clog2(WORDS)-1:0] ra,
  output logic [7:0]               rq
);

  logic [7:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/rx_stat_queue.sv
module rx_stat_queue #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LW      = 12
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic                         push,
  input  logic [3:0]                   push_err,
  input  logic [LW-1:0]                push_len,
  input  logic                         pop,
  output logic [3:0]                   head_err,
  output logic [LW-1:0]                head_len,
  output logic [$clog2(ENTRIES+1)-1:0] count
);

  localparam int unsigned IW = $clog2(ENTRIES);
  localparam int unsigned CW = $clog2(ENTRIES + 1);

  logic [3:0]    err_q [ENTRIES];
  logic [LW-1:0] len_q [ENTRIES];
  logic [IW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(ENTRIES - 1)) ? '0 : p + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      err_q[wp] <= push_err;
      len_q[wp] <= push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_err = err_q[rp];
  assign head_len = len_q[rp];
  assign count    = cnt;

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (clr)
    cnt <= CW'(ENTRIES));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
    (push && !pop) |-> (cnt != CW'(ENTRIES)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (clr)
    pop |-> (cnt != '0));

endmodule

// File: rtl/rx_wr_ctrl.sv
module rx_wr_ctrl
  import rx_pkt_fifo_pkg::*;
#(
  parameter int unsigned PW = 12
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          byte_vld,
  input  logic          frm_end,
  input  logic [3:0]    frm_err,
  input  logic          fifo_full,
  input  logic          ovr_full,
  input  logic          ovr_stat,
  output logic          receiving,
  output logic [PW-1:0] cur_len,
  output logic [PW-1:0] wr_ptr,
  output logic          store,
  output logic          push,
  output logic [3:0]    push_err,
  output logic [PW-1:0] push_len
);

  logic          recv_q, drop_q, lost_q;
  logic [PW-1:0] len_q, wp_q;
  logic          start, accept, in_frame, lose;

  assign start    = byte_vld && !recv_q && !drop_q;
  assign accept   = start && !ovr_full && !ovr_stat;
  assign in_frame = recv_q || accept;
  assign store    = byte_vld && in_frame && !fifo_full;
  assign lose     = byte_vld && in_frame && fifo_full;
  assign push     = frm_end && in_frame;
  assign push_len = len_q + PW'(store);
  assign push_err = (lost_q || lose) ? ERR_OVERRUN : frm_err;

  always_ff @(posedge clk) begin
    if (clr) begin
      recv_q <= 1'b0;
      drop_q <= 1'b0;
      lost_q <= 1'b0;
      len_q  <= '0;
      wp_q   <= '0;
    end else begin
      recv_q <= in_frame && !frm_end;
      drop_q <= (drop_q || (start && !accept)) && !frm_end;
      lost_q <= push ? 1'b0 : (lost_q || lose);
      len_q  <= push ? '0 : len_q + PW'(store);
      wp_q   <= wp_q + PW'(store);
    end
  end

  assign receiving = recv_q;
  assign cur_len   = len_q;
  assign wr_ptr    = wp_q;

  // R7 R8
  stall_refuse_chk: assert property (@(posedge clk) disable iff (clr)
    (start && (ovr_full || ovr_stat) && !frm_end) |=> !recv_q);

  // R4
  mode_excl_chk: assert property (@(posedge clk) disable iff (clr)
    !(recv_q && drop_q));

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rx_pkt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 2048,
  parameter int unsigned MAX_PKTS    = 8,
  parameter int unsigned RESUME_FREE = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mac_byte_vld,
  input  logic [7:0]  mac_byte,
  input  logic        mac_frame_end,
  input  logic [3:0]  mac_err_code,
  input  logic        host_rd,
  output logic [15:0] host_rd_data,
  output logic [15:0] host_status,
  input  logic        cmd_wr,
  input  logic [4:0]  cmd_opcode,
  output logic        rx_complete,
  output logic        rx_receiving,
  output logic        rx_fifo_ovr,
  output logic        rx_stat_ovr,
  output logic        rx_underrun,
  output logic        adapter_fail
);

  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned PW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned HW   = AW - 1;
  localparam int unsigned CW   = $clog2(MAX_PKTS + 1);

  logic [PW-1:0] wr_ptr, rd_ptr, rd_off, used, free_cnt;
  logic [PW-1:0] head_len, head_rem, cur_len, push_len, take;
  logic [3:0]    head_err, push_err;
  logic [CW-1:0] pkt_cnt;
  logic          store, push, fifo_full, have_pkt;
  logic          rst_cmd, clr, disc_cmd, do_disc;
  logic          rd_req, rd_ok, rd_bad, rd_two;
  logic          ovr_full_q, underrun_q;
  logic          keep_lo_q, keep_hi_q, odd_q;
  logic [HW-1:0] rd_idx;
  logic [7:0]    bank_q [2];
  logic [7:0]    lo_b, hi_b;
  logic [31:0]   hl32, cl32;
  rx_stat_t      stat_w;

  assign rst_cmd  = cmd_wr && (cmd_opcode == OPC_RX_RESET);
  assign disc_cmd = cmd_wr && (cmd_opcode == OPC_DISCARD);
  assign clr      = rst || rst_cmd;

  assign used      = wr_ptr - rd_ptr;
  assign free_cnt  = PW'(DEPTH) - used;
  assign fifo_full = (used == PW'(DEPTH));

  assign have_pkt = (pkt_cnt != '0);
  assign do_disc  = disc_cmd && have_pkt;
  assign head_rem = head_len - rd_off;
  assign rd_req   = host_rd && !clr && !disc_cmd;
  assign rd_ok    = rd_req && have_pkt && (head_rem != '0);
  assign rd_bad   = rd_req && !rd_ok;
  assign rd_two   = (head_rem >= PW'(2));
  assign take     = rd_two ? PW'(2) : PW'(1);

  rx_wr_ctrl #(.PW(PW)) u_wr (
    .clk       (clk),
    .clr       (clr),
    .byte_vld  (mac_byte_vld),
    .frm_end   (mac_frame_end),
    .frm_err   (mac_err_code),
    .fifo_full (fifo_full),
    .ovr_full  (ovr_full_q),
    .ovr_stat  (rx_stat_ovr),
    .receiving (rx_receiving),
    .cur_len   (cur_len),
    .wr_ptr    (wr_ptr),
    .store     (store),
    .push      (push),
    .push_err  (push_err),
    .push_len  (push_len)
  );

  rx_stat_queue #(.ENTRIES(MAX_PKTS), .LW(PW)) u_q (
    .clk      (clk),
    .clr      (clr),
    .push     (push),
    .push_err (push_err),
    .push_len (push_len),
    .pop      (do_disc),
    .head_err (head_err),
    .head_len (head_len),
    .count    (pkt_cnt)
  );

  assign rd_idx = rd_ptr[AW-1:1];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [HW-1:0] ra;
    assign ra = (b == 0 && rd_ptr[0]) ? rd_idx + HW'(1) : rd_idx;
    rx_byte_bank #(.WORDS(HALF)) u_bank (
      .clk (clk),
      .we  (store && (wr_ptr[0] == 1'(b))),
      .wa  (wr_ptr[AW-1:1]),
      .wd  (mac_byte),
      .re  (rd_req),
      .ra  (ra),
      .rq  (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_ptr     <= '0;
      rd_off     <= '0;
      ovr_full_q <= 1'b0;
      underrun_q <= 1'b0;
      keep_lo_q  <= 1'b0;
      keep_hi_q  <= 1'b0;
      odd_q      <= 1'b0;
    end else begin
      if (fifo_full)                         ovr_full_q <= 1'b1;
      else if (free_cnt >= PW'(RESUME_FREE)) ovr_full_q <= 1'b0;
      if (do_disc) begin
        rd_ptr <= rd_ptr + head_rem;
        rd_off <= '0;
      end else if (rd_ok) begin
        rd_ptr <= rd_ptr + take;
        rd_off <= rd_off + take;
      end
      if (rd_bad) underrun_q <= 1'b1;
      if (rd_req) begin
        keep_lo_q <= rd_ok;
        keep_hi_q <= rd_ok && rd_two;
        odd_q     <= rd_ptr[0];
      end
    end
  end

  assign lo_b         = odd_q ? bank_q[1] : bank_q[0];
  assign hi_b         = odd_q ? bank_q[0] : bank_q[1];
  assign host_rd_data = {keep_hi_q ? hi_b : 8'h00, keep_lo_q ? lo_b : 8'h00};

  assign hl32 = 32'(head_len);
  assign cl32 = 32'(cur_len);

  always_comb begin
    if (have_pkt) begin
      stat_w.incomplete = 1'b0;
      stat_w.code       = head_err;
      stat_w.len        = (hl32 > STAT_LEN_MAX) ? STAT_LEN_W'(STAT_LEN_MAX)
                                                : hl32[STAT_LEN_W-1:0];
    end else begin
      stat_w.incomplete = 1'b1;
      stat_w.code       = 4'b0000;
      stat_w.len        = (cl32 > STAT_LEN_MAX) ? STAT_LEN_W'(STAT_LEN_MAX)
                                                : cl32[STAT_LEN_W-1:0];
    end
  end

  assign host_status  = stat_w;
  assign rx_complete  = have_pkt;
  assign rx_stat_ovr  = (pkt_cnt == CW'(MAX_PKTS));
  assign rx_fifo_ovr  = ovr_full_q;
  assign rx_underrun  = underrun_q;
  assign adapter_fail = underrun_q;

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun_q && !rst_cmd) |=> underrun_q);

  // R8
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));

  // R6
  discard_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (do_disc && !push && !clr) |=> (pkt_cnt == $past(pkt_cnt) - CW'(1)));

endmodule

// File: tb/rx_pkt_fifo_tb.sv
`timescale 1ns/1ps
module rx_pkt_fifo_tb_top;

  localparam int DEPTH  = 64;
  localparam int MAXP   = 8;
  localparam int RESUME = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        mac_byte_vld, mac_frame_end, host_rd, cmd_wr;
  logic [7:0]  mac_byte;
  logic [3:0]  mac_err_code;
  logic [4:0]  cmd_opcode;
  logic [15:0] host_rd_data, host_status;
  logic        rx_complete, rx_receiving, rx_fifo_ovr, rx_stat_ovr;
  logic        rx_underrun, adapter_fail;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_pkt_fifo #(.DEPTH(DEPTH), .MAX_PKTS(MAXP), .RESUME_FREE(RESUME)) dut_i (
    .clk(clk), .rst(rst),
    .mac_byte_vld(mac_byte_vld), .mac_byte(mac_byte),
    .mac_frame_end(mac_frame_end), .mac_err_code(mac_err_code),
    .host_rd(host_rd), .host_rd_data(host_rd_data), .host_status(host_status),
    .cmd_wr(cmd_wr), .cmd_opcode(cmd_opcode),
    .rx_complete(rx_complete), .rx_receiving(rx_receiving),
    .rx_fifo_ovr(rx_fifo_ovr), .rx_stat_ovr(rx_stat_ovr),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
  );

  // behavioural reference model
  logic [7:0] m_data[$];
  int m_len[$];
  int m_err[$];
  int m_off, m_cur;
  bit m_recv, m_drop, m_lost, m_ovf, m_und;
  logic [15:0] m_dout;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_status();
    int l;
    if (m_len.size() > 0) begin
      l = (m_len[0] > 2047) ? 2047 : m_len[0];
      return {1'b0, 4'(m_err[0]), 11'(l)};
    end
    l = (m_cur > 2047) ? 2047 : m_cur;
    return {1'b1, 4'b0000, 11'(l)};
  endfunction

  always @(posedge clk) begin : model
    int used, rem, take, pre_cnt;
    bit full, pre_ovf, disc, rreq, rok, start, acc, inf, st, ls;
    logic [7:0] lo, hi;
    if (rst || (cmd_wr && cmd_opcode == 5'd5)) begin
      m_data.delete(); m_len.delete(); m_err.delete();
      m_off = 0; m_cur = 0; m_recv = 0; m_drop = 0; m_lost = 0;
      m_ovf = 0; m_und = 0; m_dout = 16'h0000;
    end else begin
      used = m_data.size();
      full = (used == DEPTH);
      pre_cnt = m_len.size();
      pre_ovf = m_ovf;
      if (full) m_ovf = 1;
      else if (DEPTH - used >= RESUME) m_ovf = 0;
      disc = cmd_wr && cmd_opcode == 5'd8;
      rreq = host_rd && !disc;
      rok = 0;
      rem = 0;
      if (pre_cnt > 0) rem = m_len[0] - m_off;
      if (rreq && pre_cnt > 0 && rem > 0) rok = 1;
      if (disc && pre_cnt > 0) begin
        repeat (rem) lo = m_data.pop_front();
        void'(m_len.pop_front());
        void'(m_err.pop_front());
        m_off = 0;
      end else if (rok) begin
        take = (rem >= 2) ? 2 : 1;
        lo = m_data.pop_front();
        hi = 8'h00;
        if (take == 2) hi = m_data.pop_front();
        m_off += take;
        m_dout = {hi, lo};
      end
      if (rreq && !rok) begin
        m_und = 1;
        m_dout = 16'h0000;
      end
      start = mac_byte_vld && !m_recv && !m_drop;
      acc = start && !pre_ovf && (pre_cnt != MAXP);
      inf = m_recv || acc;
      st = mac_byte_vld && inf && !full;
      ls = mac_byte_vld && inf && full;
      if (st) begin
        m_data.push_back(mac_byte);
        m_cur++;
      end
      if (ls) m_lost = 1;
      if (mac_frame_end && inf) begin
        m_len.push_back(m_cur);
        m_err.push_back(m_lost ? 8 : int'(mac_err_code));
        m_cur = 0;
        m_lost = 0;
      end
      m_drop = (m_drop || (start && !acc)) && !mac_frame_end;
      m_recv = inf && !mac_frame_end;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3", "status", 32'(host_status), 32'(exp_status()));
      chk("R5", "rx_complete", 32'(rx_complete), 32'(m_len.size() > 0));
      chk("R4", "receiving", 32'(rx_receiving), 32'(m_recv));
      chk("R7", "stat_ovr", 32'(rx_stat_ovr), 32'(m_len.size() == MAXP));
      chk("R8", "fifo_ovr", 32'(rx_fifo_ovr), 32'(m_ovf));
      chk("R10", "underrun", 32'(rx_underrun), 32'(m_und));
      chk("R10", "adapter_fail", 32'(adapter_fail), 32'(m_und));
      chk("R2", "rd_data", 32'(host_rd_data), 32'(m_dout));
    end
  end

  task automatic idle_in();
    mac_byte_vld = 0; mac_byte = 0; mac_frame_end = 0; mac_err_code = 0;
    host_rd = 0; cmd_wr = 0; cmd_opcode = 0;
  endtask

  task automatic send_frame(int n, logic [3:0] err, int base);
    for (int i = 0; i < n; i++) begin
      mac_byte_vld = 1;
      mac_byte = 8'(base + i);
      mac_frame_end = (i == n - 1);
      mac_err_code = err;
      @(negedge clk);
    end
    idle_in();
  endtask

  task automatic host_read();
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic command(logic [4:0] op);
    cmd_wr = 1;
    cmd_opcode = op;
    @(negedge clk);
    cmd_wr = 0;
    cmd_opcode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1;
    idle_in();
    @(negedge clk);
    cmp_on = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status after reset", 32'(host_status), 32'h8000);
    chk("R1", "flags after reset", 32'({rx_complete, rx_receiving, rx_fifo_ovr,
        rx_stat_ovr, rx_underrun, adapter_fail}), 32'h0);

    // R2 R3 R5: five-byte clean frame, word reads, odd tail
    send_frame(5, 4'b0000, 8'h10);
    chk("R3", "clean status", 32'(host_status), 32'h0005);
    chk("R5", "complete", 32'(rx_complete), 32'h1);
    host_read();
    chk("R2", "word0", 32'(host_rd_data), 32'h1110);
    host_read();
    chk("R2", "word1", 32'(host_rd_data), 32'h1312);
    @(negedge clk);
    chk("R2", "data held", 32'(host_rd_data), 32'h1312);
    host_read();
    chk("R2", "odd tail", 32'(host_rd_data), 32'h0014);
    // R10 read past end of head packet
    host_read();
    chk("R10", "underrun past end", 32'(rx_underrun), 32'h1);
    chk("R10", "data zero", 32'(host_rd_data), 32'h0);
    repeat (3) @(negedge clk);
    chk("R10", "underrun sticky", 32'(adapter_fail), 32'h1);
    command(5'd5);
    chk("R1", "rx reset clears", 32'({rx_underrun, rx_complete}), 32'h0);
    chk("R1", "rx reset status", 32'(host_status), 32'h8000);

    // R4 R3: in-progress frame then end with CRC code
    for (int i = 0; i < 3; i++) begin
      mac_byte_vld = 1; mac_byte = 8'(8'hA0 + i);
      @(negedge clk);
    end
    idle_in();
    chk("R4", "receiving", 32'(rx_receiving), 32'h1);
    chk("R3", "incomplete status", 32'(host_status), 32'h8003);
    mac_frame_end = 1; mac_err_code = 4'b1101;
    @(negedge clk);
    idle_in();
    chk("R4", "receiving ended", 32'(rx_receiving), 32'h0);
    chk("R3", "crc status", 32'(host_status), 32'h6803);

    // R11: stray end and foreign opcode
    mac_frame_end = 1; mac_err_code = 4'b1011;
    @(negedge clk);
    idle_in();
    command(5'd1);
    chk("R11", "unchanged status", 32'(host_status), 32'h6803);
    command(5'd8);
    chk("R6", "discard empties", 32'(host_status), 32'h8000);
    chk("R11", "no stray entry", 32'(rx_complete), 32'h0);

    // R7: status queue fills
    for (int k = 0; k < MAXP; k++) send_frame(2, 4'b0000, k * 2);
    chk("R7", "stat ovr set", 32'(rx_stat_ovr), 32'h1);
    send_frame(3, 4'b0000, 8'h70);
    chk("R7", "head still first", 32'(host_status), 32'h0002);
    command(5'd8);
    chk("R7", "stat ovr clears", 32'(rx_stat_ovr), 32'h0);
    for (int k = 1; k < MAXP; k++) command(5'd8);
    chk("R7", "dropped frame absent", 32'(host_status), 32'h8000);

    // R8 R9: store overflows mid-frame
    send_frame(70, 4'b0000, 0);
    chk("R9", "truncated status", 32'(host_status), 32'h4040);
    chk("R8", "fifo ovr set", 32'(rx_fifo_ovr), 32'h1);
    send_frame(2, 4'b0000, 8'h55);
    chk("R8", "no receive in stall", 32'(rx_receiving), 32'h0);
    host_read();
    chk("R2", "overflow word0", 32'(host_rd_data), 32'h0100);
    host_read();
    chk("R8", "ovr holds", 32'(rx_fifo_ovr), 32'h1);
    @(negedge clk);
    chk("R8", "ovr released", 32'(rx_fifo_ovr), 32'h0);
    command(5'd8);
    chk("R8", "stalled frame absent", 32'(host_status), 32'h8000);

    // R10: read with nothing held
    host_read();
    chk("R10", "underrun empty", 32'(adapter_fail), 32'h1);
    command(5'd5);
    chk("R1", "recovered", 32'(rx_underrun), 32'h0);
    repeat (2) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule